// File: doc/BRIEF.md
# Three-Level Event Interrupt Aggregator

The block gathers 96 single-cycle peripheral event pulses into three 32-bit sticky status words. Software reads these words over a simple 32-bit register bus and clears bits by writing ones to them. Three independent enable groups sit beside the status words. Each group holds three 32-bit words and drives its own level interrupt line, so any event can be routed to any combination of lines A, B and C.

For each line, a lowest-index encoder picks the first pending enabled event. It reports that event as a vector number, equal to the bit index plus 32 times the word index, together with a valid flag. The handler reads this vector register and gets the event number without scanning the status words itself. Reads and writes complete in the cycle they are presented.

Top module: `evt_irq_aggregator`

## Requirements
- R1: A pulse on event input n sets bit n%32 of status word n/32. The status words are read at byte offsets 0x00, 0x04 and 0x08. The bit stays set until it is acknowledged.
- R2: Writing to a status word clears every bit written as 1 and leaves every bit written as 0 unchanged. The cleared bits read as zero from the next cycle.
- R3: When an event pulse and an acknowledge of the same bit occur in the same cycle, the bit ends up set.
- R4: Enable group k (k = 0, 1, 2) has its word w at byte offset 0x10*(k+1) + 4*w. These words are read/write and read back the last value written.
- R5: Line k of `irq_o` (bit k) is high exactly when some status bit is set and its enable bit in group k is also 1. The line is driven from registered state with no added delay. It stays high until every such bit is acknowledged or disabled.
- R6: The vector register for line k is at byte offset 0x40 + 4*k and is read-only. Bit 31 is the valid flag. Bits 6:0 hold the lowest n whose status and group-k enable are both set, and the other bits are zero. When nothing is pending on the line, the register reads zero.
- R7: After reset, and while reset is held, all status and enable words are zero, all lines are low and every register reads zero.
- R8: Reads from any other offset return zero. Writes to any other offset, or to a vector register, change no state.
- R9: The three groups are independent. One event can drive any subset of the lines, and each line's vector register is computed only from its own group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | 96 | Event pulses, bit n is event n |
| addr_i | input | 8 | Byte address of the register access |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 3 | Level interrupt lines, bit 0 = A, 1 = B, 2 = C |

## Verification
A corrupted status or enable bit shows up on the register bus and on the affected line in the cycle after the edge that caused it. A stuck encoder shows up as a wrong vector number on the next read. Random traffic mixes acknowledges, enable updates, undefined-offset writes and sparse event bursts. After every operation the bench compares all lines against a bit-level model. At intervals it reads back every register. Directed cases cover several situations:
- an event pulse that coincides with its own acknowledge;
- events 0 and 95 at the ends of the range;
- one event routed to several lines at once.

// File: rtl/evt_agg_pkg.sv
package evt_agg_pkg;
  localparam int WORD_W     = 32;
  localparam int NUM_WORDS  = 3;
  localparam int NUM_LINES  = 3;
  localparam int NUM_EVT    = WORD_W * NUM_WORDS;
  localparam int VEC_W      = $clog2(NUM_EVT);
  localparam int ADDR_W     = 8;
  localparam int STS_BASE   = 'h00;
  localparam int GRP_STRIDE = 'h10;
  localparam int VEC_BASE   = 'h40;
endpackage

// File: rtl/evt_status_bank.sv
module evt_status_bank
  import evt_agg_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [NUM_EVT-1:0] ack_i,
  output logic [NUM_EVT-1:0] status_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_o <= '0;
    else         status_o <= (status_o & ~ack_i) | evt_i;  // set beats ack
  end

  assert_set_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((status_o & $past(evt_i)) == $past(evt_i)));

  assert_ack_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ack_i) |=> ((status_o & $past(ack_i & ~evt_i)) == '0));
endmodule

// File: rtl/evt_mask_bank.sv
module evt_mask_bank
  import evt_agg_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_WORDS-1:0] wr_en_i,
  input  logic [WORD_W-1:0]    wdata_i,
  output logic [NUM_EVT-1:0]   mask_o
);
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         mask_o[w*WORD_W +: WORD_W] <= '0;
      else if (wr_en_i[w]) mask_o[w*WORD_W +: WORD_W] <= wdata_i;
    end

    assert_mask_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i[w] |=> (mask_o[w*WORD_W +: WORD_W] == $past(wdata_i)));
  end
endmodule

// File: rtl/evt_line_select.sv
module evt_line_select
  import evt_agg_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] status_i,
  input  logic [NUM_EVT-1:0] mask_i,
  output logic               irq_o,
  output logic               valid_o,
  output logic [VEC_W-1:0]   vec_o
);
  logic [NUM_EVT-1:0] pend;
  assign pend  = status_i & mask_i;  // filter disabled events
  assign irq_o = |pend;

  always_comb begin
    valid_o = 1'b0;
    vec_o   = '0;
    for (int i = NUM_EVT - 1; i >= 0; i--) begin
      if (pend[i]) begin
        valid_o = 1'b1;
        vec_o   = VEC_W'(i);
      end
    end
  end

  assert_valid_tracks_line_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == valid_o);

  assert_vec_is_pending_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> pend[vec_o]);
endmodule

// File: rtl/evt_irq_aggregator.sv
module evt_irq_aggregator
  import evt_agg_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic [WORD_W-1:0]  wdata_i,
  output logic [WORD_W-1:0]  rdata_o,
  output logic [NUM_LINES-1:0] irq_o
);
  logic [NUM_EVT-1:0]   status;
  logic [NUM_EVT-1:0]   ack;
  logic [NUM_EVT-1:0]   mask   [NUM_LINES];
  logic [NUM_LINES-1:0] valid;
  logic [VEC_W-1:0]     vec    [NUM_LINES];
  logic [NUM_LINES-1:0] mask_hit;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_ack
    assign ack[w*WORD_W +: WORD_W] =
      (we_i && addr_i == ADDR_W'(STS_BASE + 4*w)) ? wdata_i : '0;
  end

  evt_status_bank u_status (
    .clk_i, .rst_ni, .evt_i, .ack_i(ack), .status_o(status)
  );

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
    logic [NUM_WORDS-1:0] wr_en;
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_dec
      assign wr_en[w] = we_i && addr_i == ADDR_W'(GRP_STRIDE*(k+1) + 4*w);
    end
    assign mask_hit[k] = |wr_en;

    evt_mask_bank u_mask (
      .clk_i, .rst_ni, .wr_en_i(wr_en), .wdata_i, .mask_o(mask[k])
    );

    evt_line_select u_sel (
      .clk_i, .rst_ni, .status_i(status), .mask_i(mask[k]),
      .irq_o(irq_o[k]), .valid_o(valid[k]), .vec_o(vec[k])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (addr_i == ADDR_W'(STS_BASE + 4*w)) rdata_o = status[w*WORD_W +: WORD_W];
      for (int k = 0; k < NUM_LINES; k++)
        if (addr_i == ADDR_W'(GRP_STRIDE*(k+1) + 4*w)) rdata_o = mask[k][w*WORD_W +: WORD_W];
    end
    for (int k = 0; k < NUM_LINES; k++) begin
      if (addr_i == ADDR_W'(VEC_BASE + 4*k)) begin
        rdata_o[WORD_W-1]  = valid[k];
        rdata_o[VEC_W-1:0] = vec[k];
      end
    end
  end

  assert_stray_write_keeps_masks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && mask_hit == '0) |=>
      ($stable(mask[0]) && $stable(mask[1]) && $stable(mask[2])));
endmodule

// File: tb/evt_irq_aggregator_test.sv
`timescale 1ns/100ps
module evt_irq_aggregator_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [95:0] evt_i = '0;
  logic [7:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [2:0]  irq_o;

  int n_chk = 0;
  int n_fail = 0;

  logic [95:0] m_sts;
  logic [95:0] m_msk [3];

  always #5 clk = ~clk;

  evt_irq_aggregator uut (
    .clk_i(clk), .rst_ni, .evt_i, .addr_i, .we_i, .wdata_i, .rdata_o, .irq_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_vec(input int k);
    logic [95:0] p = m_sts & m_msk[k];
    for (int i = 0; i < 96; i++)
      if (p[i]) return 32'h8000_0000 | 32'(i);
    return 32'h0;
  endfunction

  function automatic logic [2:0] exp_irq();
    logic [2:0] r;
    for (int k = 0; k < 3; k++) r[k] = |(m_sts & m_msk[k]);
    return r;
  endfunction

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr_i = a;
    #0.2;
    d = rdata_o;
  endtask

  task automatic step(input logic we, input logic [7:0] a, input logic [31:0] d,
                      input logic [95:0] e);
    @(negedge clk);
    we_i = we; addr_i = a; wdata_i = d; evt_i = e;
    @(posedge clk);
    for (int w = 0; w < 3; w++) begin
      logic [31:0] ak = (we && a == 8'(4*w)) ? d : 32'h0;
      m_sts[w*32 +: 32] = (m_sts[w*32 +: 32] & ~ak) | e[w*32 +: 32];
      for (int k = 0; k < 3; k++)
        if (we && a == 8'(16*(k+1) + 4*w)) m_msk[k][w*32 +: 32] = d;
    end
    #1;
    we_i = 1'b0; evt_i = '0;
    chk("R5 irq lines", {29'h0, irq_o}, {29'h0, exp_irq()});
  endtask

  task automatic sweep();
    logic [31:0] d;
    for (int w = 0; w < 3; w++) begin
      rd(8'(4*w), d); chk("R1 status word", d, m_sts[w*32 +: 32]);
      for (int k = 0; k < 3; k++) begin
        rd(8'(16*(k+1) + 4*w), d); chk("R4 enable word", d, m_msk[k][w*32 +: 32]);
      end
    end
    for (int k = 0; k < 3; k++) begin
      rd(8'(8'h40 + 4*k), d); chk("R6 vector", d, exp_vec(k));
    end
    rd(8'h0C, d); chk("R8 undefined read", d, 32'h0);
    rd(8'h4C, d); chk("R8 undefined read", d, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4711));
    m_sts = '0;
    for (int k = 0; k < 3; k++) m_msk[k] = '0;

    // R7: state under reset
    repeat (3) @(negedge clk);
    chk("R7 irq in reset", {29'h0, irq_o}, 32'h0);
    sweep();
    rst_ni = 1'b1;

    // R1, R5: event with no enable raises no line
    step(1'b0, 8'h00, 32'h0, 96'h20);
    sweep();
    // R9: route bit 5 to line B only
    step(1'b1, 8'h20, 32'h20, '0);
    chk("R9 only line B", {29'h0, irq_o}, 32'h2);
    rd(8'h44, d); chk("R9 vector B", d, 32'h8000_0005);
    rd(8'h40, d); chk("R9 vector A empty", d, 32'h0);
    // R6: event 95 on lines A and C, event 0 lower on C
    step(1'b1, 8'h18, 32'h8000_0000, '0);
    step(1'b1, 8'h38, 32'h8000_0000, {1'b1, 95'h0});
    rd(8'h40, d); chk("R6 vector 95", d, 32'h8000_005F);
    step(1'b1, 8'h30, 32'h1, 96'h1);
    rd(8'h48, d); chk("R6 lowest wins", d, 32'h8000_0000);
    sweep();
    // R3: ack and event on the same bit
    step(1'b1, 8'h00, 32'h20, 96'h20);
    rd(8'h00, d); chk("R3 set wins", d & 32'h20, 32'h20);
    // R2: write 0 keeps, write 1 clears
    step(1'b1, 8'h00, 32'h0, '0);
    rd(8'h00, d); chk("R2 zero write keeps", d, 32'h21);
    step(1'b1, 8'h00, 32'h20, '0);
    chk("R5 line B drops", {31'h0, irq_o[1]}, 32'h0);
    // R8: stray writes
    step(1'b1, 8'h1C, 32'hFFFF_FFFF, '0);
    step(1'b1, 8'h40, 32'hFFFF_FFFF, '0);
    sweep();

    for (int n = 0; n < 600; n++) begin
      logic [7:0]  a;
      logic [95:0] e;
      int sel = $urandom_range(0, 15);
      if (sel < 3)       a = 8'(4*sel);
      else if (sel < 12) a = 8'(16*((sel-3)/3 + 1) + 4*((sel-3)%3));
      else if (sel == 12) a = 8'h0C;
      else if (sel == 13) a = 8'h44;
      else               a = 8'($urandom_range(0, 255));
      e = {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom}
        & {$urandom, $urandom, $urandom};
      if ($urandom_range(0, 1) == 0) e = '0;
      step($urandom_range(0, 3) != 0, a, $urandom, e);
      if (n % 25 == 0) sweep();
    end
    sweep();

    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule